// File: doc/BRIEF.md
# Accumulator Bit and Digit Rotator

This unit performs the rotate operations of a small 8-bit processor core. A single-bit rotate moves the accumulator one position left or right. In the plain form the bit that leaves one end re-enters at the other end and is also copied into the carry flag. In the through-carry form the carry flag becomes a ninth bit of the ring.

Two further operations rotate 4-bit digits around a ring made of the accumulator's low nibble and the two nibbles of a memory byte. For these, the unit fetches the byte through a request/acknowledge read port and returns the updated byte through a one-cycle write strobe. The address of the byte and the memory itself are handled outside this unit.

The core pulses `start` with an opcode, the accumulator and the carry flag. It then waits for `done`. On the cycle after `done`, `accOut` and `carryOut` hold the results, and they stay there until the next operation. The `fastMem` input, sampled with `start`, tells the unit whether the operand byte lies in fast internal storage, which sets the digit-rotate latency.

Top module: `acc_rotate_unit`

## Requirements
- R1: After reset, `accOut`, `carryOut`, `memWrData`, `busy`, `done`, `memRdReq` and `memWr` are all 0.
- R2: Opcode 000 rotates right and opcode 001 rotates left, without the old carry. The bit leaving the accumulator goes both to the opposite end and to `carryOut`. The previous carry has no effect.
- R3: Opcode 010 rotates right through carry: bit 0 goes to the carry and the old carry enters at bit 7. Opcode 011 rotates left through carry: bit 7 goes to the carry and the old carry enters at bit 0.
- R4: Opcode 100 (digit right) sets the new accumulator low nibble to the memory low nibble. The new memory high nibble becomes the old accumulator low nibble, and the new memory low nibble becomes the old memory high nibble.
- R5: Opcode 101 (digit left) sets the new accumulator low nibble to the memory high nibble. The new memory low nibble becomes the old accumulator low nibble, and the new memory high nibble becomes the old memory low nibble.
- R6: Digit rotates return the accumulator high nibble and the carry flag unchanged.
- R7: Single-bit rotates and reserved opcodes keep `busy` high for exactly 2 cycles after the `start` edge, with `done` high in the second of them.
- R8: A digit rotate keeps `busy` high for 10 cycles when `fastMem` is 1 and 12 cycles when it is 0, provided `memRdAck` answers in the first request cycle. Each cycle the acknowledge is withheld adds one cycle.
- R9: `memWr` pulses exactly once per digit rotate, in the cycle where `done` is high. Neither `memWr` nor `memRdReq` is ever raised for any other opcode.
- R10: Reserved opcodes 110 and 111 return the accumulator and carry unchanged.
- R11: `start` is ignored while `busy` is high, so the running operation's results are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| opcode | input | 3 | Operation select |
| accIn | input | 8 | Accumulator operand |
| carryIn | input | 1 | Carry flag operand |
| fastMem | input | 1 | Operand byte lies in fast storage |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final cycle of the operation |
| accOut | output | 8 | Resulting accumulator |
| carryOut | output | 1 | Resulting carry flag |
| memRdReq | output | 1 | Memory byte read request |
| memRdAck | input | 1 | Read data valid this cycle |
| memRdData | input | 8 | Memory byte read data |
| memWr | output | 1 | Write-back strobe for the updated byte |
| memWrData | output | 8 | Updated memory byte |

## Verification
A wrong rotate or digit path appears on `accOut`, `carryOut` or `memWrData` in the cycle right after `done`. The vector table covers every opcode with bit patterns chosen so that each end bit and each nibble is distinct, which exposes any swap. A sequencing fault in the control (a miscounted delay, a lost acknowledge, a duplicated or misplaced write strobe) changes the number of `busy` cycles, or the position and count of `memWr` pulses, within the same operation. The bench measures all of these for each operation, including ones with stalled acknowledges and a `start` that arrives while the unit is busy.

// File: rtl/acc_rot_pkg.sv
package acc_rot_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;

  typedef enum logic [2:0] {
    OP_ROR  = 3'b000,
    OP_ROL  = 3'b001,
    OP_RORC = 3'b010,
    OP_ROLC = 3'b011,
    OP_DIGR = 3'b100,
    OP_DIGL = 3'b101
  } rotOp_e;

  typedef struct packed {
    logic loadOps;
    logic loadMem;
    logic doRotate;
  } rotStrobes_t;

  function automatic logic isDigitOp(input logic [2:0] op);
    return op[2:1] == 2'b10;
  endfunction
endpackage

// File: rtl/acc_rot_datapath.sv
module acc_rot_datapath
  import acc_rot_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rotStrobes_t       strb,
  input  logic [2:0]        opcode,
  input  logic [DATA_W-1:0] accIn,
  input  logic              carryIn,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] accOut,
  output logic              carryOut,
  output logic [DATA_W-1:0] memOut
);
  localparam int HI = DATA_W - 1;

  logic [2:0]        opReg;
  logic [DATA_W-1:0] accReg, memReg, accNext, memNext;
  logic              cyReg, cyNext;

  always_comb begin
    accNext = accReg;
    memNext = memReg;
    cyNext  = cyReg;
    unique case (opReg)
      OP_ROR:  begin accNext = {accReg[0], accReg[HI:1]}; cyNext = accReg[0];  end
      OP_ROL:  begin accNext = {accReg[HI-1:0], accReg[HI]}; cyNext = accReg[HI]; end
      OP_RORC: begin accNext = {cyReg, accReg[HI:1]}; cyNext = accReg[0];  end
      OP_ROLC: begin accNext = {accReg[HI-1:0], cyReg}; cyNext = accReg[HI]; end
      OP_DIGR: begin
        accNext = {accReg[HI:NIB_W], memReg[NIB_W-1:0]};
        memNext = {accReg[NIB_W-1:0], memReg[HI:NIB_W]};
      end
      OP_DIGL: begin
        accNext = {accReg[HI:NIB_W], memReg[HI:NIB_W]};
        memNext = {memReg[NIB_W-1:0], accReg[NIB_W-1:0]};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg  <= '0;
      accReg <= '0;
      memReg <= '0;
      cyReg  <= 1'b0;
    end else if (strb.loadOps) begin
      opReg  <= opcode;
      accReg <= accIn;
      cyReg  <= carryIn;
    end else if (strb.loadMem) begin
      memReg <= memRdData;
    end else if (strb.doRotate) begin
      accReg <= accNext;
      memReg <= memNext;
      cyReg  <= cyNext;
    end
  end

  assign accOut   = accReg;
  assign carryOut = cyReg;
  assign memOut   = memReg;

  // R6
  digit_keeps_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doRotate && isDigitOp(opReg)) |=>
      (accReg[HI:NIB_W] == $past(accReg[HI:NIB_W]) && cyReg == $past(cyReg)));

  // R11
  op_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadOps |=> $stable(opReg));
endmodule

// File: rtl/acc_rot_control.sv
module acc_rot_control
  import acc_rot_pkg::*;
#(
  parameter int FAST_CYCLES = 10,
  parameter int SLOW_CYCLES = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  opcode,
  input  logic        fastMem,
  input  logic        memRdAck,
  output rotStrobes_t strb,
  output logic        busy,
  output logic        done,
  output logic        memRdReq,
  output logic        memWr
);
  localparam int OVERHEAD = 3;
  localparam int FAST_DLY = FAST_CYCLES - OVERHEAD;
  localparam int SLOW_DLY = SLOW_CYCLES - OVERHEAD;
  localparam int CNT_W    = $clog2(SLOW_CYCLES + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_READ, ST_DELAY, ST_EXEC, ST_FIN} rotState_e;

  rotState_e  state;
  logic [CNT_W-1:0] cnt;
  logic       digitOp, fastReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      digitOp <= 1'b0;
      fastReg <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          digitOp <= isDigitOp(opcode);
          fastReg <= fastMem;
          state   <= isDigitOp(opcode) ? ST_READ : ST_EXEC;
        end
        ST_READ: if (memRdAck) begin
          cnt   <= fastReg ? CNT_W'(FAST_DLY - 1) : CNT_W'(SLOW_DLY - 1);
          state <= ST_DELAY;
        end
        ST_DELAY: begin
          if (cnt == '0) state <= ST_EXEC;
          else           cnt   <= cnt - 1'b1;
        end
        ST_EXEC: state <= ST_FIN;
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.loadOps  = (state == ST_IDLE) && start;
    strb.loadMem  = (state == ST_READ) && memRdAck;
    strb.doRotate = (state == ST_EXEC);
  end

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_FIN);
  assign memRdReq = (state == ST_READ);
  assign memWr    = (state == ST_FIN) && digitOp;

  // R9
  wr_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWr |=> !memWr && !busy);

  // R9
  rd_in_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> busy && !done);

  // R7
  done_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy && !done);

  // R8
  ack_advances_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && memRdAck) |=> !memRdReq && busy);

  initial begin
    // R8
    delay_param_chk: assert (FAST_DLY >= 1 && SLOW_DLY >= 1);
  end
endmodule

// File: rtl/acc_rotate_unit.sv
module acc_rotate_unit
  import acc_rot_pkg::*;
#(
  parameter int FAST_CYCLES = 10,
  parameter int SLOW_CYCLES = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] opcode,
  input  logic [7:0] accIn,
  input  logic       carryIn,
  input  logic       fastMem,
  output logic       busy,
  output logic       done,
  output logic [7:0] accOut,
  output logic       carryOut,
  output logic       memRdReq,
  input  logic       memRdAck,
  input  logic [7:0] memRdData,
  output logic       memWr,
  output logic [7:0] memWrData
);
  rotStrobes_t strb;

  acc_rot_control #(
    .FAST_CYCLES(FAST_CYCLES),
    .SLOW_CYCLES(SLOW_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .fastMem(fastMem), .memRdAck(memRdAck), .strb(strb),
    .busy(busy), .done(done), .memRdReq(memRdReq), .memWr(memWr)
  );

  acc_rot_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opcode(opcode),
    .accIn(accIn), .carryIn(carryIn), .memRdData(memRdData),
    .accOut(accOut), .carryOut(carryOut), .memOut(memWrData)
  );
endmodule

// File: tb/tb_acc_rotate_unit.sv
module tb_acc_rotate_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [2:0] opcode = '0;
  logic [7:0] accIn = '0;
  logic       carryIn = 1'b0;
  logic       fastMem = 1'b0;
  logic       memRdAck = 1'b0;
  logic [7:0] memRdData = '0;
  logic       busy, done, carryOut, memRdReq, memWr;
  logic [7:0] accOut, memWrData;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  acc_rotate_unit dut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .accIn(accIn),
    .carryIn(carryIn), .fastMem(fastMem), .busy(busy), .done(done),
    .accOut(accOut), .carryOut(carryOut), .memRdReq(memRdReq),
    .memRdAck(memRdAck), .memRdData(memRdData), .memWr(memWr),
    .memWrData(memWrData)
  );

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] acc;
    logic       cy;
    logic [7:0] mem;
    logic       fast;
    logic [7:0] eAcc;
    logic       eCy;
    logic [7:0] eMem;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 8'h81, 1'b0, 8'h00, 1'b1, 8'hC0, 1'b1, 8'h00},
    '{3'd0, 8'h02, 1'b1, 8'h00, 1'b1, 8'h01, 1'b0, 8'h00},
    '{3'd1, 8'h81, 1'b0, 8'h00, 1'b1, 8'h03, 1'b1, 8'h00},
    '{3'd1, 8'h40, 1'b1, 8'h00, 1'b1, 8'h80, 1'b0, 8'h00},
    '{3'd2, 8'h01, 1'b0, 8'h00, 1'b1, 8'h00, 1'b1, 8'h00},
    '{3'd2, 8'h02, 1'b1, 8'h00, 1'b1, 8'h81, 1'b0, 8'h00},
    '{3'd3, 8'h80, 1'b0, 8'h00, 1'b1, 8'h00, 1'b1, 8'h00},
    '{3'd3, 8'h40, 1'b1, 8'h00, 1'b1, 8'h81, 1'b0, 8'h00},
    '{3'd4, 8'hA5, 1'b1, 8'h3C, 1'b1, 8'hAC, 1'b1, 8'h53},
    '{3'd5, 8'h71, 1'b0, 8'hE2, 1'b0, 8'h7E, 1'b0, 8'h21},
    '{3'd4, 8'h96, 1'b0, 8'h1F, 1'b0, 8'h9F, 1'b0, 8'h61},
    '{3'd6, 8'h5A, 1'b1, 8'h00, 1'b1, 8'h5A, 1'b1, 8'h00},
    '{3'd7, 8'hC3, 1'b0, 8'h00, 1'b0, 8'hC3, 1'b0, 8'h00}
  };

  int   gotLat, wrCnt, rdCycles, doneCnt;
  bit   wrWithDone, doneLast;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [2:0] op, input logic [7:0] acc,
                       input logic cy, input logic [7:0] mem, input logic fast,
                       input int stall, input bit poke);
    int stallLeft = stall;
    @(negedge clk);
    start = 1'b1; opcode = op; accIn = acc; carryIn = cy; fastMem = fast;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; accIn = 8'h00; carryIn = ~cy; fastMem = ~fast;
    gotLat = 0; wrCnt = 0; rdCycles = 0; doneCnt = 0;
    wrWithDone = 1'b1; doneLast = 1'b0;
    while (busy && gotLat < 100) begin
      gotLat++;
      if (poke && gotLat == 1) begin
        start = 1'b1; opcode = 3'd1; accIn = 8'hFF; carryIn = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (memRdReq) begin
        rdCycles++;
        if (stallLeft > 0) begin
          stallLeft--; memRdAck = 1'b0; memRdData = 8'hXX ^ 8'h00;
        end else begin
          memRdAck = 1'b1; memRdData = mem;
        end
      end else begin
        memRdAck = 1'b0;
      end
      if (memWr) begin
        wrCnt++;
        if (!done) wrWithDone = 1'b0;
      end
      if (done) doneCnt++;
      doneLast = done;
      @(negedge clk);
    end
    start = 1'b0; memRdAck = 1'b0;
  endtask

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd4:       return "R4";
      3'd5:       return "R5";
      default:    return "R10";
    endcase
  endfunction

  initial begin
    #(4 * 20000);
    if (!finished) begin
      failCnt++;
      testCnt++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(accOut == 8'h00 && carryOut == 1'b0 && memWrData == 8'h00, "R1",
          "reset data", {accOut, carryOut, memWrData}, 0);
    check(!busy && !done && !memRdReq && !memWr, "R1", "reset controls",
          {busy, done, memRdReq, memWr}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v = VECS[i];
      bit dig = (v.op[2:1] == 2'b10);
      int expLat = dig ? (v.fast ? 10 : 12) : 2;
      runOp(v.op, v.acc, v.cy, v.mem, v.fast, 0, 1'b0);
      check(accOut == v.eAcc, reqOf(v.op), "accOut", accOut, v.eAcc);
      check(carryOut == v.eCy, dig ? "R6" : reqOf(v.op), "carryOut",
            carryOut, v.eCy);
      if (dig) begin
        check(memWrData == v.eMem, reqOf(v.op), "memWrData", memWrData, v.eMem);
        check(accOut[7:4] == v.acc[7:4], "R6", "acc high nibble",
              accOut[7:4], v.acc[7:4]);
        // R8 latency
        check(gotLat == expLat, "R8", "busy cycles", gotLat, expLat);
        // R9 one write, with done
        check(wrCnt == 1 && wrWithDone, "R9", "write strobes", wrCnt, 1);
      end else begin
        // R7 latency
        check(gotLat == expLat, "R7", "busy cycles", gotLat, expLat);
        // R9 no memory traffic
        check(wrCnt == 0 && rdCycles == 0, "R9", "mem traffic",
              wrCnt + rdCycles, 0);
      end
      check(doneCnt == 1 && doneLast, dig ? "R8" : "R7", "done on final cycle",
            doneCnt, 1);
    end

    // R8 stalled acknowledge: three withheld cycles add three
    runOp(3'd5, 8'h3B, 1'b1, 8'h8D, 1'b1, 3, 1'b0);
    check(gotLat == 13, "R8", "stalled busy cycles", gotLat, 13);
    check(rdCycles == 4, "R8", "read request cycles", rdCycles, 4);
    check(accOut == 8'h38 && memWrData == 8'hDB && carryOut == 1'b1, "R5",
          "stalled digit left", {accOut, memWrData}, 16'h38DB);
    check(wrCnt == 1 && wrWithDone, "R9", "stalled write strobes", wrCnt, 1);

    // R11 start while busy is ignored
    runOp(3'd2, 8'h10, 1'b1, 8'h00, 1'b1, 0, 1'b1);
    check(accOut == 8'h88 && carryOut == 1'b0, "R11", "result after poke",
          {accOut, carryOut}, 9'h110);
    check(gotLat == 2, "R11", "busy cycles after poke", gotLat, 2);
    @(negedge clk);
    check(!busy, "R11", "no second op started", busy, 0);

    // R11 poke during digit rotate
    runOp(3'd4, 8'h00, 1'b0, 8'hF0, 1'b0, 0, 1'b1);
    check(accOut == 8'h00 && memWrData == 8'h0F && carryOut == 1'b0, "R11",
          "digit after poke", {accOut, memWrData}, 16'h000F);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule